// File: doc/BRIEF.md
# Flag-Offset Source Register Selector

This block is the operand-fetch stage of a small scalar unit that has 32 general registers and four 16-bit condition registers. Each cycle it may accept one 32-bit instruction word. It decodes the source-1 and source-2 register fields, the condition-select field and the flag-select field, and it presents registered read addresses for the general register file one cycle later. Alongside the addresses it presents a normalised opcode, in which alias encodings are folded onto their base opcode.

The block holds the four condition registers. The arithmetic datapath loads them through a flag write port. The block uses them for one special addressing mode. When the flag-select field holds the value 4, bits 5:4 of a chosen condition register are added to the low two bits of the source-2 index. The carry out of that addition is dropped, so the operand rotates inside its aligned group of four registers.

The block also recognises two kinds of opcode in the upper half of the opcode space. The first kind does nothing except clear the flags of a destination condition register. The second is a single full no-operation. For each, the block raises a strobe for the sequencer.

Top module: `flag_offset_fetch`

## Requirements
- R1: Instruction fields are placed as follows: opcode in bits 30:24, source-1 index in bits 18:14, source-2 index in bits 13:9, flag-select in bits 8:5, condition-select in bits 4:3 and destination condition register in bits 1:0. When flag-select equals 4, the source-2 read address equals the source-2 index with bits 5:4 of the selected condition register added to its low two bits.
- R2: The carry out of source-2 index bit 1 is discarded, so bits 4:2 of the source-2 address always equal bits 4:2 of the source-2 field (for example, field 31 with offset 3 gives 30).
- R3: The condition-select field (bits 4:3) chooses which of the four condition registers supplies the offset.
- R4: For any flag-select value other than 4, the source-2 address equals the source-2 field unchanged.
- R5: Opcodes 0x40-0x7f other than 0x41, 0x42, 0x45, 0x48-0x4e, 0x4f, 0x51, 0x58-0x5e, 0x6a, 0x6b, 0x7a and 0x7b are clear-only. For these, flagClr is high, flagClrIdx carries the destination field, and that condition register becomes zero. Opcodes 0x00-0x3f never clear.
- R6: Opcode 0x4f raises nopOut, leaves flagClr low and leaves every condition register unchanged.
- R7: opCode shows 0x41, 0x48, 0x49, 0x4c and 0x4d for inputs 0x51, 0x58, 0x59, 0x5c and 0x5d respectively. Every other opcode passes through unchanged.
- R8: The source-1 address equals the instruction bits 18:14, with no offset applied.
- R9: All outputs are registered. outValid is high exactly one cycle after instValid, and flagClr and nopOut are low whenever outValid is low.
- R10: When a clear-only instruction and a flag write target the same condition register in the same cycle, the register ends at zero. An offset read uses the condition value held before that cycle's flag write.
- R11: Reset zeroes every condition register. A flag write (flagWrEn, flagWrIdx, flagWrData) loads the addressed register, which then holds its value until the next write or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction word valid this cycle |
| instWord | input | 32 | Instruction word |
| flagWrEn | input | 1 | Datapath flag write enable |
| flagWrIdx | input | 2 | Condition register written by the datapath |
| flagWrData | input | 16 | Flag value written by the datapath |
| outValid | output | 1 | Registered outputs are valid |
| src1Addr | output | 5 | Source-1 register read address |
| src2Addr | output | 5 | Source-2 register read address after offset |
| opCode | output | 7 | Opcode with aliases folded |
| flagClr | output | 1 | Instruction cleared a condition register |
| flagClrIdx | output | 2 | Condition register that was cleared |
| nopOut | output | 1 | Instruction is a full no-operation |

## Verification
Two functions can fall in the same cycle. The first is the datapath's flag write. The second is the instruction stream's use of the same condition register, either as a clear target or as the source of the offset. The bench drives an instruction and a flag write to one register on the same clock edge. It then judges the outcome through a follow-up instruction with flag-select 4. The offset that instruction produces shows whether the clear took priority (R10), and whether the first instruction saw the value held before the write.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;
  localparam int OP_W = 7;

  // Strobes handed from the decoder to the datapath.
  typedef struct packed {
    logic            clrEn;   // clear-only opcode
    logic            nopEn;   // full no-operation
    logic            ofsEn;   // source-2 offset mode active
    logic [OP_W-1:0] normOp;  // opcode with aliases folded
  } fetchCtrl_t;
endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import opfetch_pkg::*;
#(
  parameter int SEL_W        = 4,
  parameter int OFS_SEL_CODE = 4
) (
  input  logic [OP_W-1:0]  opField,
  input  logic [SEL_W-1:0] flagSel,
  output fetchCtrl_t       ctrl
);
  localparam logic [OP_W-1:0] ALIAS_BIT = OP_W'(7'h10);

  always_comb begin
    ctrl = '0;
    ctrl.ofsEn = (flagSel == SEL_W'(OFS_SEL_CODE));

    // Classify: real operations, the single no-op, and clear-only codes.
    case (opField) inside
      7'h41, 7'h42, 7'h45, [7'h48:7'h4e], 7'h51, [7'h58:7'h5e],
      7'h6a, 7'h6b, 7'h7a, 7'h7b: ctrl.clrEn = 1'b0;
      7'h4f:                      ctrl.nopEn = 1'b1;
      default:                    ctrl.clrEn = opField[OP_W-1];
    endcase

    // Fold alias encodings onto their base opcode.
    case (opField)
      7'h51, 7'h58, 7'h59, 7'h5c, 7'h5d: ctrl.normOp = opField & ~ALIAS_BIT;
      default:                           ctrl.normOp = opField;
    endcase
  end

  // R6: a no-op never clears flags
  always_comb begin
    p_clr_nop_excl_r6: assert (!(ctrl.clrEn && ctrl.nopEn));
  end
endmodule

// File: rtl/fetch_dpath.sv
module fetch_dpath
  import opfetch_pkg::*;
#(
  parameter int REG_IDX_W  = 5,
  parameter int COND_SEL_W = 2,
  parameter int FLAG_W     = 16,
  parameter int OFS_POS    = 4,
  parameter int GRP_W      = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  instValid,
  input  logic [REG_IDX_W-1:0]  src1Idx,
  input  logic [REG_IDX_W-1:0]  src2Idx,
  input  logic [COND_SEL_W-1:0] condSel,
  input  logic [COND_SEL_W-1:0] dstCond,
  input  fetchCtrl_t            ctrl,
  input  logic                  flagWrEn,
  input  logic [COND_SEL_W-1:0] flagWrIdx,
  input  logic [FLAG_W-1:0]     flagWrData,
  output logic                  outValid,
  output logic [REG_IDX_W-1:0]  src1Addr,
  output logic [REG_IDX_W-1:0]  src2Addr,
  output logic [OP_W-1:0]       opCode,
  output logic                  flagClr,
  output logic [COND_SEL_W-1:0] flagClrIdx,
  output logic                  nopOut
);
  localparam int COND_CNT = 1 << COND_SEL_W;

  logic [FLAG_W-1:0]    condRegs [COND_CNT];
  logic                 clrNow;
  logic [GRP_W-1:0]     ofsVal;
  logic [GRP_W-1:0]     lowSum;
  logic [REG_IDX_W-1:0] effSrc2;

  assign clrNow = instValid && ctrl.clrEn;

  // Condition registers: an instruction clear overrides a datapath write.
  for (genvar gi = 0; gi < COND_CNT; gi++) begin : g_cond
    always_ff @(posedge clk) begin
      if (!rstN)
        condRegs[gi] <= '0;
      else if (clrNow && dstCond == COND_SEL_W'(gi))
        condRegs[gi] <= '0;
      else if (flagWrEn && flagWrIdx == COND_SEL_W'(gi))
        condRegs[gi] <= flagWrData;
    end
  end

  // Rotate source-2 inside its aligned group; the carry is dropped by width.
  assign ofsVal  = ctrl.ofsEn ? condRegs[condSel][OFS_POS +: GRP_W] : '0;
  assign lowSum  = src2Idx[GRP_W-1:0] + ofsVal;
  assign effSrc2 = {src2Idx[REG_IDX_W-1:GRP_W], lowSum};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      src1Addr   <= '0;
      src2Addr   <= '0;
      opCode     <= '0;
      flagClr    <= 1'b0;
      flagClrIdx <= '0;
      nopOut     <= 1'b0;
    end else begin
      outValid   <= instValid;
      src1Addr   <= src1Idx;
      src2Addr   <= effSrc2;
      opCode     <= ctrl.normOp;
      flagClr    <= clrNow;
      flagClrIdx <= dstCond;
      nopOut     <= instValid && ctrl.nopEn;
    end
  end

  // R5 / R10: the cleared register reads zero once the strobe is out
  p_cleared_r5: assert property (@(posedge clk) disable iff (!rstN)
    flagClr |-> condRegs[flagClrIdx] == '0);
  // R2: the group bits never move
  p_group_kept_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> src2Addr[REG_IDX_W-1:GRP_W] == $past(src2Idx[REG_IDX_W-1:GRP_W]));
  // R4: no offset outside the offset mode
  p_plain_src2_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(ctrl.ofsEn)) |-> src2Addr == $past(src2Idx));
  // R8: source-1 is passed straight through
  p_src1_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> src1Addr == $past(src1Idx));
  // R9: one cycle of latency
  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    instValid |=> outValid);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!flagClr && !nopOut));
endmodule

// File: rtl/flag_offset_fetch.sv
module flag_offset_fetch
  import opfetch_pkg::*;
#(
  parameter int REG_IDX_W  = 5,
  parameter int COND_SEL_W = 2,
  parameter int FLAG_W     = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  instValid,
  input  logic [31:0]           instWord,
  input  logic                  flagWrEn,
  input  logic [COND_SEL_W-1:0] flagWrIdx,
  input  logic [FLAG_W-1:0]     flagWrData,
  output logic                  outValid,
  output logic [REG_IDX_W-1:0]  src1Addr,
  output logic [REG_IDX_W-1:0]  src2Addr,
  output logic [OP_W-1:0]       opCode,
  output logic                  flagClr,
  output logic [COND_SEL_W-1:0] flagClrIdx,
  output logic                  nopOut
);
  fetchCtrl_t ctrl;

  fetch_ctrl #(.SEL_W(4), .OFS_SEL_CODE(4)) u_ctrl (
    .opField (instWord[30:24]),
    .flagSel (instWord[8:5]),
    .ctrl    (ctrl)
  );

  fetch_dpath #(
    .REG_IDX_W (REG_IDX_W),
    .COND_SEL_W(COND_SEL_W),
    .FLAG_W    (FLAG_W),
    .OFS_POS   (4),
    .GRP_W     (2)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .src1Idx   (instWord[18:14]),
    .src2Idx   (instWord[13:9]),
    .condSel   (instWord[4:3]),
    .dstCond   (instWord[1:0]),
    .ctrl      (ctrl),
    .flagWrEn  (flagWrEn),
    .flagWrIdx (flagWrIdx),
    .flagWrData(flagWrData),
    .outValid  (outValid),
    .src1Addr  (src1Addr),
    .src2Addr  (src2Addr),
    .opCode    (opCode),
    .flagClr   (flagClr),
    .flagClrIdx(flagClrIdx),
    .nopOut    (nopOut)
  );
endmodule

// File: tb/tb_flag_offset_fetch.sv
`timescale 1ns/1ps
module tb_flag_offset_fetch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic        flagWrEn = 1'b0;
  logic [1:0]  flagWrIdx = '0;
  logic [15:0] flagWrData = '0;
  logic        outValid, flagClr, nopOut;
  logic [4:0]  src1Addr, src2Addr;
  logic [6:0]  opCode;
  logic [1:0]  flagClrIdx;

  always #2 clk = ~clk;

  flag_offset_fetch dut (.*);

  typedef struct packed {
    logic [4:0]  s1;
    logic [4:0]  s2;
    logic [6:0]  op;
    logic        clr;
    logic [1:0]  clrIdx;
    logic        nop;
    logic [31:0] cyc;
  } item_t;

  item_t       expQ[$];
  string       tagQ[$];
  logic [15:0] model [4];
  int          checkCnt = 0;
  int          failCnt = 0;
  int unsigned cycle = 0;
  bit          done = 1'b0;

  always @(posedge clk) cycle <= cycle + 1;

  function automatic bit isExec(input logic [6:0] op);
    return (op < 7'h40) || op == 7'h41 || op == 7'h42 || op == 7'h45 ||
           (op >= 7'h48 && op <= 7'h4e) || op == 7'h51 ||
           (op >= 7'h58 && op <= 7'h5e) || op == 7'h6a || op == 7'h6b ||
           op == 7'h7a || op == 7'h7b;
  endfunction

  function automatic logic [6:0] foldOp(input logic [6:0] op);
    if (op == 7'h51 || op == 7'h58 || op == 7'h59 || op == 7'h5c || op == 7'h5d)
      return op - 7'h10;
    return op;
  endfunction

  task automatic check(input bit ok, input string tag, input string msg);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic issue(input logic [6:0] op, input logic [4:0] s1, input logic [4:0] s2,
                       input logic [3:0] fs, input logic [1:0] cs, input logic [1:0] dc,
                       input string tag, input bit doW = 1'b0,
                       input logic [1:0] wI = '0, input logic [15:0] wD = '0);
    item_t e;
    logic [1:0] ofs;
    @(negedge clk);
    instWord   = {1'b0, op, 5'd0, s1, s2, fs, cs, 1'b0, dc};
    instValid  = 1'b1;
    flagWrEn   = doW;
    flagWrIdx  = wI;
    flagWrData = wD;
    ofs = (fs == 4'd4) ? model[cs][5:4] : 2'd0;
    e.s1     = s1;
    e.s2     = {s2[4:2], s2[1:0] + ofs};
    e.op     = foldOp(op);
    e.clr    = !isExec(op) && op != 7'h4f;
    e.clrIdx = dc;
    e.nop    = (op == 7'h4f);
    e.cyc    = cycle + 1;
    expQ.push_back(e);
    tagQ.push_back(tag);
    if (doW) model[wI] = wD;
    if (e.clr) model[dc] = '0;
  endtask

  task automatic loadFlag(input logic [1:0] idx, input logic [15:0] data);
    @(negedge clk);
    instValid  = 1'b0;
    flagWrEn   = 1'b1;
    flagWrIdx  = idx;
    flagWrData = data;
    model[idx] = data;
  endtask

  task automatic idle();
    @(negedge clk);
    instValid = 1'b0;
    flagWrEn  = 1'b0;
  endtask

  // Monitor: pop and compare as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9", "outValid with nothing issued");
        end else begin
          item_t e, g;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          g = {src1Addr, src2Addr, opCode, flagClr, flagClrIdx, nopOut, cycle};
          check(g == e, t, $sformatf("got s1=%0d s2=%0d op=%h clr=%b idx=%0d nop=%b cyc=%0d exp s1=%0d s2=%0d op=%h clr=%b idx=%0d nop=%b cyc=%0d",
                g.s1, g.s2, g.op, g.clr, g.clrIdx, g.nop, g.cyc,
                e.s1, e.s2, e.op, e.clr, e.clrIdx, e.nop, e.cyc));
        end
      end else if (rstN && (flagClr || nopOut)) begin
        check(1'b0, "R9", $sformatf("strobe while idle clr=%b nop=%b exp 0 0", flagClr, nopOut));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !flagClr && !nopOut, "R9",
          $sformatf("reset state valid=%b clr=%b nop=%b exp 0 0 0", outValid, flagClr, nopOut));

    // R11: registers start at zero, so offset mode gives no offset
    for (int c = 0; c < 4; c++) issue(7'h41, 5'd4, 5'd17, 4'd4, c[1:0], 2'd0, "R11_reset");

    // R11: load offsets 0,1,3,2
    loadFlag(2'd0, 16'h8000);
    loadFlag(2'd1, 16'h8090);
    loadFlag(2'd2, 16'h80b0);
    loadFlag(2'd3, 16'h80a0);

    // R1/R3: offset from each selected register, group 16..19
    for (int s = 16; s < 20; s++)
      for (int c = 0; c < 4; c++)
        issue(7'h41, 5'(s - 12), 5'(s), 4'd4, c[1:0], 2'd0, "R1_R3_offset");

    // R2: carry out of bit 1 discarded
    issue(7'h41, 5'd1, 5'd31, 4'd4, 2'd2, 2'd0, "R2_wrap");
    issue(7'h4c, 5'd2, 5'd6,  4'd4, 2'd3, 2'd0, "R2_wrap");

    // R4: other flag-select values
    issue(7'h41, 5'd3, 5'd18, 4'd0,  2'd2, 2'd0, "R4_plain");
    issue(7'h41, 5'd3, 5'd18, 4'd5,  2'd2, 2'd0, "R4_plain");
    issue(7'h41, 5'd3, 5'd18, 4'd12, 2'd3, 2'd0, "R4_plain");

    // R8: source-1 field
    issue(7'h42, 5'd31, 5'd0, 4'd0, 2'd0, 2'd0, "R8_src1");
    issue(7'h42, 5'd10, 5'd0, 4'd0, 2'd0, 2'd0, "R8_src1");

    // R7: aliases and a non-alias
    issue(7'h51, 5'd1, 5'd1, 4'd0, 2'd0, 2'd0, "R7_alias");
    issue(7'h58, 5'd1, 5'd1, 4'd0, 2'd0, 2'd0, "R7_alias");
    issue(7'h59, 5'd1, 5'd1, 4'd0, 2'd0, 2'd0, "R7_alias");
    issue(7'h5c, 5'd1, 5'd1, 4'd0, 2'd0, 2'd0, "R7_alias");
    issue(7'h5d, 5'd1, 5'd1, 4'd0, 2'd0, 2'd0, "R7_alias");
    issue(7'h5e, 5'd1, 5'd1, 4'd0, 2'd0, 2'd0, "R7_passthru");

    // R6: full no-op leaves register 2 at offset 3
    issue(7'h4f, 5'd0, 5'd0, 4'd4, 2'd2, 2'd2, "R6_nop");
    issue(7'h41, 5'd0, 5'd20, 4'd4, 2'd2, 2'd0, "R6_kept");

    // R5: clear-only opcodes, then observe via offset
    issue(7'h60, 5'd0, 5'd0, 4'd0, 2'd0, 2'd1, "R5_clear");
    issue(7'h41, 5'd0, 5'd20, 4'd4, 2'd1, 2'd0, "R5_after");
    issue(7'h43, 5'd0, 5'd0, 4'd0, 2'd0, 2'd3, "R5_clear");
    issue(7'h41, 5'd0, 5'd21, 4'd4, 2'd3, 2'd0, "R5_after");
    issue(7'h1f, 5'd0, 5'd0, 4'd0, 2'd0, 2'd2, "R5_lowrange");
    issue(7'h41, 5'd0, 5'd20, 4'd4, 2'd2, 2'd0, "R5_lowkept");
    issue(7'h7a, 5'd0, 5'd0, 4'd0, 2'd0, 2'd2, "R5_exec");

    // R10: same-cycle write and read uses old value; then new value
    loadFlag(2'd3, 16'h0020);
    issue(7'h41, 5'd0, 5'd8, 4'd4, 2'd3, 2'd0, "R10_oldval", 1'b1, 2'd3, 16'h0010);
    issue(7'h41, 5'd0, 5'd8, 4'd4, 2'd3, 2'd0, "R10_newval");
    // R10: clear beats a same-cycle write
    issue(7'h70, 5'd0, 5'd0, 4'd0, 2'd0, 2'd2, "R10_clrwins", 1'b1, 2'd2, 16'h0030);
    issue(7'h41, 5'd0, 5'd9, 4'd4, 2'd2, 2'd0, "R10_after");

    idle();
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R9",
          $sformatf("pending results %0d exp 0", expQ.size()));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule